// File: doc/BRIEF.md
# Ripple Magnitude Comparator with Minimum

This block compares two unsigned operands of a parameterised width and reports which of the two is larger. It is also the smaller-value picker for its surroundings. The comparison runs through a chain of identical one-bit cells. The cell for the most significant bit starts the chain with an "equal so far" state. Each cell passes a greater / equal / less triple down to the next less significant bit. Once a cell sees a differing bit pair while the incoming state is still "equal", the verdict is fixed, and the cells below it can no longer change it.

The final triple controls a two-way selector. The selector returns operand A when A is strictly smaller and operand B in every other case. The three flags and the selected value are captured in output registers on the rising clock edge. A user therefore applies operands in one cycle and reads the verdict and the minimum after the next edge. A synchronous active-high reset sets the registers to the state that a comparison of two zero operands would give.

Top module: `ripple_cmp_min`

## Requirements
- R1: The outputs `gt`, `eq`, `lt` and `min_val` are registered. They show the result for the `op_a`/`op_b` values present at the rising clock edge and hold it until the next edge.
- R2: While `rst` is 1 at a rising edge, the outputs become gt=0, eq=1, lt=0 and min_val=0, whatever the operands are.
- R3: After every edge, exactly one of `gt`, `eq` and `lt` is 1.
- R4: `gt` is 1 exactly when `op_a` is greater than `op_b` as unsigned numbers. For example, a=4'b1011 and b=4'b1001 give gt=1.
- R5: `lt` is 1 exactly when `op_a` is less than `op_b` as unsigned numbers.
- R6: `eq` is 1 exactly when `op_a` and `op_b` are identical in every bit.
- R7: The most significant differing bit alone sets the verdict, whatever the lower bits hold. For example, 8'h80 against 8'h7F gives gt=1.
- R8: `min_val` equals `op_a` when `op_a` is less than `op_b`, and equals `op_b` otherwise. When the operands are equal, this is the shared value.
- R9: The width `WIDTH` is a parameter. The same behaviour holds for WIDTH=4 over all operand pairs and for the default WIDTH=8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | WIDTH | Unsigned operand A |
| op_b | input | WIDTH | Unsigned operand B |
| gt | output | 1 | Registered: A greater than B |
| eq | output | 1 | Registered: A equal to B |
| lt | output | 1 | Registered: A less than B |
| min_val | output | WIDTH | Registered: the smaller operand |

## Verification
The operands are applied on a falling edge. They are captured by the next rising edge, so all four results are due together one clock later. The monitor reads them a quarter period after that rising edge. For every operand pair that the driver applies, it queues one expected item. The monitor removes one item after each rising edge that follows a push, so every comparison is tied to the edge that captured its operands. The reset checks run with the queue empty and sample right after the edge at which `rst` was high.

// File: rtl/cmp_pkg.sv
package cmp_pkg;

  // Relation triple carried from one bit cell to the next.
  typedef struct packed {
    logic gt;
    logic eq;
    logic lt;
  } rel_t;

  // State that enters the most significant cell: nothing decided yet.
  localparam rel_t REL_SEED = '{gt: 1'b0, eq: 1'b1, lt: 1'b0};

endpackage

// File: rtl/mag_bit_stage.sv
module mag_bit_stage
  import cmp_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  rel_t upper,
  output rel_t lower
);

  logic a_wins;
  logic b_wins;

  assign a_wins = a_bit & ~b_bit;
  assign b_wins = ~a_bit & b_bit;

  // A decision made above is kept; this bit decides only while still equal.
  assign lower.gt = upper.gt | (upper.eq & a_wins);
  assign lower.lt = upper.lt | (upper.eq & b_wins);
  assign lower.eq = upper.eq & ~(a_bit ^ b_bit);

endmodule

// File: rtl/mag_ripple_chain.sv
module mag_ripple_chain
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output rel_t             verdict
);

  // link[WIDTH] is the seed, link[0] the final verdict.
  rel_t link [WIDTH:0];

  assign link[WIDTH] = REL_SEED;

  for (genvar i = WIDTH - 1; i >= 0; i--) begin : g_cell
    mag_bit_stage u_cell (
      .a_bit (a[i]),
      .b_bit (b[i]),
      .upper (link[i+1]),
      .lower (link[i])
    );
  end

  assign verdict = link[0];

endmodule

// File: rtl/min_pick.sv
module min_pick #(
  parameter int WIDTH = 8
) (
  input  logic             take_a,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] y
);

  assign y = take_a ? a : b;

endmodule

// File: rtl/ripple_cmp_min.sv
module ripple_cmp_min
  import cmp_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  output logic             gt,
  output logic             eq,
  output logic             lt,
  output logic [WIDTH-1:0] min_val
);

  rel_t             rel_c;
  logic [WIDTH-1:0] min_c;

  mag_ripple_chain #(.WIDTH(WIDTH)) u_chain (
    .a       (op_a),
    .b       (op_b),
    .verdict (rel_c)
  );

  min_pick #(.WIDTH(WIDTH)) u_pick (
    .take_a (rel_c.lt),
    .a      (op_a),
    .b      (op_b),
    .y      (min_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gt      <= 1'b0;
      eq      <= 1'b1;
      lt      <= 1'b0;
      min_val <= '0;
    end else begin
      gt      <= rel_c.gt;
      eq      <= rel_c.eq;
      lt      <= rel_c.lt;
      min_val <= min_c;
    end
  end

endmodule

// File: rtl/ripple_cmp_min_chk.sv
module ripple_cmp_min_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic             gt,
  input logic             eq,
  input logic             lt,
  input logic [WIDTH-1:0] min_val
);

  // R2: a reset edge leaves the "equal, zero" state
  p_reset_state_r2: assert property (@(posedge clk)
    $past(rst) |-> (eq && !gt && !lt && min_val == '0));

  // R3: one verdict flag at a time
  p_one_flag_r3: assert property (@(posedge clk) disable iff (rst)
    $countones({gt, eq, lt}) == 1);

  // R4 / R1: greater flag follows the previous cycle's operands
  p_gt_match_r4: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (gt == ($past(op_a) > $past(op_b))));

  // R5: less flag follows the previous cycle's operands
  p_lt_match_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (lt == ($past(op_a) < $past(op_b))));

  // R6: equal flag follows the previous cycle's operands
  p_eq_match_r6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (eq == ($past(op_a) == $past(op_b))));

  // R8: minimum never exceeds either operand and is one of them
  p_min_bound_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (min_val <= $past(op_a) && min_val <= $past(op_b)
                     && (min_val == $past(op_a) || min_val == $past(op_b))));

endmodule

bind ripple_cmp_min ripple_cmp_min_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .op_a    (op_a),
  .op_b    (op_b),
  .gt      (gt),
  .eq      (eq),
  .lt      (lt),
  .min_val (min_val)
);

// File: tb/ripple_cmp_min_tb.sv
module ripple_cmp_min_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W8 = 8;
  localparam int W4 = 4;

  typedef struct {
    logic [W8-1:0] a8;
    logic [W8-1:0] b8;
    logic [W4-1:0] a4;
    logic [W4-1:0] b4;
    string         tag;
  } item_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W8-1:0] a8 = '0, b8 = '0;
  logic [W4-1:0] a4 = '0, b4 = '0;
  logic gt8, eq8, lt8, gt4, eq4, lt4;
  logic [W8-1:0] min8;
  logic [W4-1:0] min4;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ripple_cmp_min #(.WIDTH(W8)) u_dut (
    .clk(clk), .rst(rst), .op_a(a8), .op_b(b8),
    .gt(gt8), .eq(eq8), .lt(lt8), .min_val(min8)
  );

  ripple_cmp_min #(.WIDTH(W4)) u_dut4 (
    .clk(clk), .rst(rst), .op_a(a4), .op_b(b4),
    .gt(gt4), .eq(eq4), .lt(lt4), .min_val(min4)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // Driver: apply operands on a falling edge and queue the expectation.
  task automatic drive(input logic [W8-1:0] x8, input logic [W8-1:0] y8,
                       input logic [W4-1:0] x4, input logic [W4-1:0] y4,
                       input string tag);
    item_t it;
    @(negedge clk);
    a8 = x8; b8 = y8; a4 = x4; b4 = y4;
    it.a8 = x8; it.b8 = y8; it.a4 = x4; it.b4 = y4; it.tag = tag;
    sb_q.push_back(it);
  endtask

  // Monitor: results are due one rising edge after the operands were applied.
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (sb_q.size() > 0) begin
      item_t it;
      logic [W8-1:0] m8;
      logic [W4-1:0] m4;
      it = sb_q.pop_front();
      m8 = (it.a8 < it.b8) ? it.a8 : it.b8;
      m4 = (it.a4 < it.b4) ? it.a4 : it.b4;
      check(gt8 == (it.a8 > it.b8), {"R4 gt w8 ", it.tag}, gt8, it.a8 > it.b8);
      check(lt8 == (it.a8 < it.b8), {"R5 lt w8 ", it.tag}, lt8, it.a8 < it.b8);
      check(eq8 == (it.a8 == it.b8), {"R6 eq w8 ", it.tag}, eq8, it.a8 == it.b8);
      check(min8 == m8, {"R8 min w8 ", it.tag}, min8, m8);
      check($countones({gt8, eq8, lt8}) == 1, {"R3 flags w8 ", it.tag},
            {gt8, eq8, lt8}, 0);
      check(gt4 == (it.a4 > it.b4), {"R9 gt w4 ", it.tag}, gt4, it.a4 > it.b4);
      check(lt4 == (it.a4 < it.b4), {"R9 lt w4 ", it.tag}, lt4, it.a4 < it.b4);
      check(eq4 == (it.a4 == it.b4), {"R9 eq w4 ", it.tag}, eq4, it.a4 == it.b4);
      check(min4 == m4, {"R9 min w4 ", it.tag}, min4, m4);
    end
  end

  task automatic check_reset_state(input string tag);
    check(gt8 == 1'b0 && eq8 == 1'b1 && lt8 == 1'b0, {"R2 flags ", tag},
          {gt8, eq8, lt8}, 3'b010);
    check(min8 == '0, {"R2 min ", tag}, min8, 0);
    check(gt4 == 1'b0 && eq4 == 1'b1 && lt4 == 1'b0 && min4 == '0,
          {"R2 w4 ", tag}, {gt4, eq4, lt4, min4}, 7'b0100000);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    a8 = 8'hC3; b8 = 8'h11; a4 = 4'hA; b4 = 4'h2;
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check_reset_state("initial");
    @(negedge clk);
    rst = 1'b0;

    // R4: the worked example, in both widths
    drive(8'b0000_1011, 8'b0000_1001, 4'b1011, 4'b1001, "R4 example");
    // R7: the top differing bit wins against all lower bits
    drive(8'h80, 8'h7F, 4'h8, 4'h7, "R7 msb");
    drive(8'h7F, 8'h80, 4'h7, 4'h8, "R7 msb rev");
    drive(8'hA0, 8'hA1, 4'h2, 4'h3, "R7 lsb");
    // R6 / R8: equal operands, the minimum is the shared value
    drive(8'h5A, 8'h5A, 4'hF, 4'hF, "R6 equal");
    drive(8'h00, 8'h00, 4'h0, 4'h0, "R6 zero");
    drive(8'hFF, 8'h00, 4'hF, 4'h0, "R4 extremes");
    drive(8'h00, 8'hFF, 4'h0, 4'hF, "R5 extremes");

    // R1: one result per edge over back-to-back operands; R9 exhaustive at width 4
    for (int i = 0; i < 256; i++) begin
      drive(8'($urandom), 8'($urandom), 4'(i >> 4), 4'(i), "R1 sweep");
    end
    // R9 random pairs at the default width, some forced equal
    for (int k = 0; k < 1500; k++) begin
      logic [W8-1:0] ra;
      logic [W8-1:0] rb;
      ra = 8'($urandom);
      rb = (k % 7 == 0) ? ra : 8'($urandom);
      drive(ra, rb, 4'($urandom), 4'($urandom), "R9 random");
    end

    // R2: reset in the middle of traffic, with operands that would give gt
    @(negedge clk);
    a8 = 8'hF0; b8 = 8'h0F; a4 = 4'hC; b4 = 4'h3;
    rst = 1'b1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    check_reset_state("mid-run");
    @(negedge clk);
    rst = 1'b0;
    drive(8'h10, 8'h20, 4'h1, 4'h2, "R5 after reset");
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    check(sb_q.size() == 0, "R1 queue drained", sb_q.size(), 0);
    finish_run();
  end

endmodule